// File: doc/BRIEF.md
# Adaptive Delta Nibble Decoder

This block turns a stream of 4-bit adaptive delta codes into signed 16-bit audio samples. It produces one scaled sample per output tick. Each code moves a running prediction by an odd multiple of the current step size, with the sign taken from the code's top bit. The same code also scales the step size up or down, so the decoder follows loud and quiet passages on its own. Both the prediction and the step have their own clamps.

A fractional phase accumulator sets the pace. On each tick a 16-bit rate value is added to a phase that has 14 fractional bits. Every whole unit carried out of the phase makes the decoder pull one nibble through a valid/ready handshake, so a single tick can consume zero to four nibbles. The sample that comes out is a linear blend of the prediction before and after the last nibble. The blend is weighted by the phase fraction that remains, then multiplied by an unsigned 8-bit volume. A restart pulse returns the decoder to its initial state from anywhere.

Top module: `delta_nibble_decoder`

## Requirements
- R1: After reset, or in the cycle after `restart` is high, the prediction, the saved previous prediction, the phase and `smp_out` are all zero, the step size is 127, and `smp_valid` and `nib_ready` are low. `restart` overrides a tick or decode that is in progress.
- R2: Each consumed code `c` changes the prediction by `(2*(c mod 8)+1) * step / 8`, with the division truncated toward zero. The change is subtracted when bit 3 of `c` is 1 and added when it is 0.
- R3: After each code the step becomes `step * k / 64`, truncated, where `k` for the low three code bits 0..7 is 57, 57, 57, 57, 77, 102, 128, 153. The result is clamped to 127..24576.
- R4: The prediction saturates to the range -32768..32767 and does not wrap.
- R5: A tick accepted while idle adds `rate` to the 14-bit fractional phase. The integer carry, 0 to 4, is the exact number of nibbles consumed before the sample is emitted. The phase keeps only the fraction.
- R6: While a nibble is needed, `nib_ready` stays high. When `nib_valid` is low, the prediction and step hold and `nib_code` is ignored.
- R7: Once the needed nibbles are consumed, `smp_valid` pulses for one cycle. With it, `smp_out = floor((prev*(16384-f) + cur*f) / 16384) * volume`, where `f` is the phase fraction, `cur` is the prediction and `prev` is the prediction held before the last code. `smp_out` holds between pulses.
- R8: A tick that arrives while a decode or an emit is in progress is ignored and leaves the phase unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous return to the initial decode state |
| tick | input | 1 | Output-rate tick request |
| rate | input | 16 | Phase increment per tick, 14 fractional bits |
| volume | input | 8 | Unsigned linear output gain |
| nib_valid | input | 1 | A code is present on `nib_code` |
| nib_code | input | 4 | Delta code: bit 3 is the sign, bits 2..0 the magnitude index |
| nib_ready | output | 1 | The decoder takes a code this cycle if valid |
| smp_valid | output | 1 | One-cycle pulse marking a new sample |
| smp_out | output | 24 | Signed interpolated sample times volume |

## Verification
The assertions assume that `restart` is a clean synchronous pulse and that `tick` is sampled only when it changes away from the clock edge. They also assume that reset is held low from time zero, so the past values they compare are defined. The stimulus drives every input on the falling edge. It sends ticks only while the decoder is idle, except for the deliberate busy-time ticks that exercise the ignore rule. It keeps the valid probability above zero so that every decode finishes.

// File: rtl/dnd_pkg.sv
package dnd_pkg;

   typedef enum logic [1:0] {
      DND_IDLE,
      DND_DECODE,
      DND_EMIT
   } dnd_state_e;

   // step growth factor in 1/64 units, picked by the magnitude bits of a code
   function automatic logic [7:0] dnd_step_scale(input logic [2:0] idx);
      case (idx)
         3'd4:    return 8'd77;
         3'd5:    return 8'd102;
         3'd6:    return 8'd128;
         3'd7:    return 8'd153;
         default: return 8'd57;
      endcase
   endfunction

endpackage

// File: rtl/dnd_nibble_step.sv
module dnd_nibble_step #(
   parameter int PRED_W   = 16,
   parameter int STEP_W   = 15,
   parameter int STEP_MIN = 127,
   parameter int STEP_MAX = 24576
) (
   input  logic [3:0]               code,
   input  logic signed [PRED_W-1:0] pred_i,
   input  logic [STEP_W-1:0]        step_i,
   output logic signed [PRED_W-1:0] pred_o,
   output logic [STEP_W-1:0]        step_o
);
   import dnd_pkg::*;

   localparam int MAG_W  = STEP_W + 4;
   localparam int DIV_W  = MAG_W - 3;
   localparam int SUM_W  = ((PRED_W > DIV_W + 1) ? PRED_W : DIV_W + 1) + 1;
   localparam int SPR_W  = STEP_W + 8;
   localparam int P_HI_I = (1 << (PRED_W - 1)) - 1;
   localparam int P_LO_I = -(1 << (PRED_W - 1));

   logic [3:0]               odd;
   logic [MAG_W-1:0]         mag_prod;
   logic [DIV_W-1:0]         mag_div;
   logic signed [SUM_W-1:0]  pred_x;
   logic signed [SUM_W-1:0]  diff_x;
   logic signed [SUM_W-1:0]  sum_x;
   logic [SPR_W-1:0]         step_prod;
   logic [SPR_W-1:0]         step_div;

   // odd multiplier 1,3,..,15 from the magnitude bits
   assign odd      = {code[2:0], 1'b1};
   assign mag_prod = MAG_W'(odd) * MAG_W'(step_i);
   // magnitude is shifted before the sign is applied: truncation toward zero
   assign mag_div  = DIV_W'(mag_prod >> 3);
   assign pred_x   = SUM_W'(pred_i);
   assign diff_x   = SUM_W'($signed({1'b0, mag_div}));
   assign sum_x    = code[3] ? (pred_x - diff_x) : (pred_x + diff_x);

   always_comb begin
      if (sum_x > SUM_W'(P_HI_I))
         pred_o = PRED_W'(P_HI_I);
      else if (sum_x < SUM_W'(P_LO_I))
         pred_o = PRED_W'(P_LO_I);
      else
         pred_o = PRED_W'(sum_x);
   end

   assign step_prod = SPR_W'(step_i) * SPR_W'(dnd_step_scale(code[2:0]));
   assign step_div  = step_prod >> 6;

   always_comb begin
      if (step_div > SPR_W'(STEP_MAX))
         step_o = STEP_W'(STEP_MAX);
      else if (step_div < SPR_W'(STEP_MIN))
         step_o = STEP_W'(STEP_MIN);
      else
         step_o = STEP_W'(step_div);
   end

endmodule

// File: rtl/dnd_interp.sv
module dnd_interp #(
   parameter int PRED_W = 16,
   parameter int FRAC_W = 14,
   parameter int VOL_W  = 8,
   parameter int OUT_W  = 24
) (
   input  logic signed [PRED_W-1:0] prev_i,
   input  logic signed [PRED_W-1:0] cur_i,
   input  logic [FRAC_W-1:0]        frac_i,
   input  logic [VOL_W-1:0]         vol_i,
   output logic signed [OUT_W-1:0]  out_o
);
   localparam int WGT_W = FRAC_W + 1;
   localparam int ACC_W = PRED_W + WGT_W + 2;

   logic [WGT_W-1:0]         w_prev;
   logic [WGT_W-1:0]         w_cur;
   logic signed [ACC_W-1:0]  p_prev;
   logic signed [ACC_W-1:0]  p_cur;
   logic signed [ACC_W-1:0]  acc;
   logic signed [PRED_W-1:0] mix;

   assign w_cur  = {1'b0, frac_i};
   assign w_prev = (WGT_W'(1) << FRAC_W) - w_cur;
   assign p_prev = ACC_W'(prev_i) * ACC_W'($signed({1'b0, w_prev}));
   assign p_cur  = ACC_W'(cur_i)  * ACC_W'($signed({1'b0, w_cur}));
   assign acc    = p_prev + p_cur;
   // arithmetic shift gives floor; weights sum to one so the range is preserved
   assign mix    = PRED_W'(acc >>> FRAC_W);
   assign out_o  = OUT_W'(mix) * OUT_W'($signed({1'b0, vol_i}));

endmodule

// File: rtl/delta_nibble_decoder.sv
module delta_nibble_decoder #(
   parameter int RATE_W   = 16,
   parameter int FRAC_W   = 14,
   parameter int PRED_W   = 16,
   parameter int STEP_MIN = 127,
   parameter int STEP_MAX = 24576,
   parameter int VOL_W    = 8,
   parameter int OUT_W    = PRED_W + VOL_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     restart,
   input  logic                     tick,
   input  logic [RATE_W-1:0]        rate,
   input  logic [VOL_W-1:0]         volume,
   input  logic                     nib_valid,
   input  logic [3:0]               nib_code,
   output logic                     nib_ready,
   output logic                     smp_valid,
   output logic signed [OUT_W-1:0]  smp_out
);
   import dnd_pkg::*;

   localparam int STEP_W = $clog2(STEP_MAX + 1);
   localparam int SUM_W  = RATE_W + 1;
   localparam int CNT_W  = SUM_W - FRAC_W;

   if (RATE_W < FRAC_W) begin : g_bad_rate
      $error("rate must be at least as wide as the phase fraction");
   end
   if (STEP_MIN < 1 || STEP_MIN > STEP_MAX) begin : g_bad_step
      $error("step clamp bounds are inconsistent");
   end
   if (OUT_W < PRED_W + VOL_W) begin : g_bad_out
      $error("output too narrow for sample times volume");
   end

   dnd_state_e               state_q;
   logic [FRAC_W-1:0]        phase_q;
   logic [CNT_W-1:0]         pend_q;
   logic signed [PRED_W-1:0] pred_q;
   logic signed [PRED_W-1:0] prev_q;
   logic [STEP_W-1:0]        step_q;
   logic signed [OUT_W-1:0]  smp_out_q;
   logic                     smp_valid_q;

   logic [SUM_W-1:0]         phase_sum;
   logic [CNT_W-1:0]         carry;
   logic signed [PRED_W-1:0] pred_nx;
   logic [STEP_W-1:0]        step_nx;
   logic signed [OUT_W-1:0]  mix_out;

   assign phase_sum = SUM_W'(phase_q) + SUM_W'(rate);
   assign carry     = phase_sum[SUM_W-1:FRAC_W];
   assign nib_ready = (state_q == DND_DECODE) && !restart;
   assign smp_valid = smp_valid_q;
   assign smp_out   = smp_out_q;

   dnd_nibble_step #(
      .PRED_W  (PRED_W),
      .STEP_W  (STEP_W),
      .STEP_MIN(STEP_MIN),
      .STEP_MAX(STEP_MAX)
   ) u_step (
      .code  (nib_code),
      .pred_i(pred_q),
      .step_i(step_q),
      .pred_o(pred_nx),
      .step_o(step_nx)
   );

   dnd_interp #(
      .PRED_W(PRED_W),
      .FRAC_W(FRAC_W),
      .VOL_W (VOL_W),
      .OUT_W (OUT_W)
   ) u_interp (
      .prev_i(prev_q),
      .cur_i (pred_q),
      .frac_i(phase_q),
      .vol_i (volume),
      .out_o (mix_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= DND_IDLE;
         phase_q     <= '0;
         pend_q      <= '0;
         pred_q      <= '0;
         prev_q      <= '0;
         step_q      <= STEP_W'(STEP_MIN);
         smp_out_q   <= '0;
         smp_valid_q <= 1'b0;
      end else if (restart) begin
         state_q     <= DND_IDLE;
         phase_q     <= '0;
         pend_q      <= '0;
         pred_q      <= '0;
         prev_q      <= '0;
         step_q      <= STEP_W'(STEP_MIN);
         smp_out_q   <= '0;
         smp_valid_q <= 1'b0;
      end else begin
         case (state_q)
            DND_IDLE: begin
               smp_valid_q <= 1'b0;
               if (tick) begin
                  phase_q <= phase_sum[FRAC_W-1:0];
                  pend_q  <= carry;
                  state_q <= (carry == '0) ? DND_EMIT : DND_DECODE;
               end
            end
            DND_DECODE: begin
               if (nib_valid) begin
                  prev_q <= pred_q;
                  pred_q <= pred_nx;
                  step_q <= step_nx;
                  pend_q <= pend_q - CNT_W'(1);
                  if (pend_q == CNT_W'(1))
                     state_q <= DND_EMIT;
               end
            end
            DND_EMIT: begin
               smp_out_q   <= mix_out;
               smp_valid_q <= 1'b1;
               state_q     <= DND_IDLE;
            end
            default: state_q <= DND_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/dnd_checker.sv
module dnd_checker #(
   parameter int FRAC_W   = 14,
   parameter int PRED_W   = 16,
   parameter int STEP_W   = 15,
   parameter int STEP_MIN = 127,
   parameter int STEP_MAX = 24576,
   parameter int OUT_W    = 24
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     restart,
   input logic                     nib_valid,
   input logic                     nib_ready,
   input logic                     smp_valid,
   input logic signed [OUT_W-1:0]  smp_out,
   input logic signed [PRED_W-1:0] pred,
   input logic signed [PRED_W-1:0] prev,
   input logic [STEP_W-1:0]        step,
   input logic [FRAC_W-1:0]        phase,
   input logic                     busy
);

   p_restart_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (pred == '0 && prev == '0 && phase == '0 &&
                   step == STEP_W'(STEP_MIN) && smp_out == '0 && !smp_valid));

   p_step_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step >= STEP_W'(STEP_MIN) && step <= STEP_W'(STEP_MAX)));

   p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (nib_ready && !nib_valid && !restart) |=>
         ($stable(pred) && $stable(prev) && $stable(step)));

   p_pulse_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |=> !smp_valid);

   p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !restart |=> (smp_valid || $stable(smp_out)));

   p_busy_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !restart) |=> $stable(phase));

endmodule

bind delta_nibble_decoder dnd_checker #(
   .FRAC_W  (FRAC_W),
   .PRED_W  (PRED_W),
   .STEP_W  (STEP_W),
   .STEP_MIN(STEP_MIN),
   .STEP_MAX(STEP_MAX),
   .OUT_W   (OUT_W)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .restart  (restart),
   .nib_valid(nib_valid),
   .nib_ready(nib_ready),
   .smp_valid(smp_valid),
   .smp_out  (smp_out),
   .pred     (pred_q),
   .prev     (prev_q),
   .step     (step_q),
   .phase    (phase_q),
   .busy     (state_q != dnd_pkg::DND_IDLE)
);

// File: tb/delta_nibble_decoder_tb.sv
`timescale 1ns/1ps
module delta_nibble_decoder_tb_top;

   localparam int FRAC = 14;
   localparam int ONE  = 1 << FRAC;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               restart = 1'b0;
   logic               tick = 1'b0;
   logic [15:0]        rate = '0;
   logic [7:0]         volume = '0;
   logic               nib_valid = 1'b0;
   logic [3:0]         nib_code = '0;
   logic               nib_ready;
   logic               smp_valid;
   logic signed [23:0] smp_out;

   int checks = 0;
   int fails  = 0;
   int m_pred, m_prev, m_step, m_phase;

   always #2.5 clk = ~clk;

   delta_nibble_decoder dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (restart),
      .tick     (tick),
      .rate     (rate),
      .volume   (volume),
      .nib_valid(nib_valid),
      .nib_code (nib_code),
      .nib_ready(nib_ready),
      .smp_valid(smp_valid),
      .smp_out  (smp_out)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   function automatic int grow(input int idx);
      case (idx)
         4: return 77;
         5: return 102;
         6: return 128;
         7: return 153;
         default: return 57;
      endcase
   endfunction

   function automatic void model_nib(input int code);
      int odd;
      odd = 2 * (code % 8) + 1;
      if (code >= 8) odd = -odd;
      m_prev = m_pred;
      m_pred = m_pred + (odd * m_step) / 8;
      if (m_pred > 32767) m_pred = 32767;
      if (m_pred < -32768) m_pred = -32768;
      m_step = (m_step * grow(code % 8)) / 64;
      if (m_step > 24576) m_step = 24576;
      if (m_step < 127) m_step = 127;
   endfunction

   function automatic longint model_out(input int vol);
      longint a;
      a = longint'(m_prev) * (ONE - m_phase) + longint'(m_pred) * m_phase;
      a = a >>> FRAC;
      return a * vol;
   endfunction

   function automatic int pick(input int fixed_code);
      if (fixed_code < 0) return int'($urandom_range(15));
      return fixed_code;
   endfunction

   task automatic do_restart();
      @(negedge clk);
      restart = 1'b1;
      @(negedge clk);
      restart = 1'b0;
      m_pred = 0; m_prev = 0; m_step = 127; m_phase = 0;
      chk(smp_out == 0, "R1 output cleared", longint'(smp_out), 0);
      chk(!smp_valid && !nib_ready, "R1 idle after restart",
          longint'({smp_valid, nib_ready}), 0);
   endtask

   task automatic do_tick(input int rate_v, input int vol_v, input int pct,
                          input int fixed_code, input bit busy_tick, input string req);
      int need, got, cyc, code;
      bit tick_done;
      @(negedge clk);
      rate = 16'(rate_v); volume = 8'(vol_v); tick = 1'b1;
      need    = (m_phase + rate_v) >> FRAC;
      m_phase = (m_phase + rate_v) % ONE;
      code = pick(fixed_code);
      got = 0; cyc = 0; tick_done = 1'b0;
      @(negedge clk);
      forever begin
         tick = 1'b0;
         if (smp_valid) break;
         if (cyc > 2000) begin
            chk(1'b0, {req, " R5 decode never finished"}, cyc, 0);
            break;
         end
         nib_valid = (int'($urandom_range(99)) < pct);
         if (busy_tick && !tick_done && nib_ready && !nib_valid) begin
            tick = 1'b1;              // R8: must be ignored
            rate = 16'($urandom);
            tick_done = 1'b1;
         end
         nib_code = nib_valid ? 4'(code) : 4'($urandom_range(15));
         if (nib_valid && nib_ready) begin
            model_nib(code);
            got++;
            code = pick(fixed_code);
         end
         @(negedge clk);
         cyc++;
      end
      nib_valid = 1'b0;
      tick = 1'b0;
      chk(got == need, {req, " R5 nibbles per tick"}, got, need);
      chk(longint'(smp_out) == model_out(vol_v), {req, " R7 sample value"},
          longint'(smp_out), model_out(vol_v));
   endtask

   task automatic stall_then_restart();
      @(negedge clk);
      rate = 16'(3 * ONE); tick = 1'b1; nib_valid = 1'b0;
      @(negedge clk);
      tick = 1'b0;
      for (int i = 0; i < 5; i++) begin
         nib_code = 4'($urandom_range(15));
         chk(nib_ready == 1'b1, "R6 ready held while stalled", nib_ready, 1);
         chk(smp_valid == 1'b0, "R6 no sample while stalled", smp_valid, 0);
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog R5 act=timeout exp=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      m_pred = 0; m_prev = 0; m_step = 127; m_phase = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(smp_out == 0, "R1 reset output", longint'(smp_out), 0);
      chk(!smp_valid && !nib_ready, "R1 reset handshake",
          longint'({smp_valid, nib_ready}), 0);

      do_restart();
      // step floor: small codes keep shrinking the step (R2, R3)
      for (int i = 0; i < 6; i++) do_tick(ONE, 255, 100, 0, 1'b0, "R2 R3 floor");
      do_tick(ONE + 5000, 200, 100, 4, 1'b0, "R2 code4");
      // step ceiling and positive saturation (R3, R4)
      for (int i = 0; i < 10; i++) do_tick(16'hFFFF, 3, 100, 7, 1'b0, "R3 R4 up");
      // negative saturation (R4)
      for (int i = 0; i < 10; i++) do_tick(16'hFFFF, 255, 60, 15, 1'b0, "R4 down");
      // no-carry ticks and fractional phase (R5)
      for (int i = 0; i < 3; i++) do_tick(0, 77, 100, -1, 1'b0, "R5 zero rate");
      for (int i = 0; i < 8; i++) do_tick(7000, 129, 100, -1, 1'b0, "R5 frac");
      // ticks while busy (R8)
      for (int i = 0; i < 5; i++) do_tick(40000, 17, 30, -1, 1'b1, "R8 busy tick");
      // stall then restart mid decode (R6, R1)
      stall_then_restart();
      do_restart();
      do_tick(ONE, 1, 100, 7, 1'b0, "R1 R2 after abort");
      // random mix
      for (int i = 0; i < 300; i++)
         do_tick(int'($urandom_range(65535)), int'($urandom_range(255)),
                 int'($urandom_range(100, 20)), -1, ($urandom_range(3) == 0), "rand R2 R3 R7");
      repeat (2) @(negedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule